// File: doc/BRIEF.md
# Coprocessor Operand-Store Response Sequencer

This block is the coprocessor half of a host/coprocessor dialog for an instruction that converts a floating-point register to an external format and writes it to memory. On a command it captures a 3-bit destination-format code, a 7-bit extension field and the exception-enable bits. It then presents a fixed series of response primitives on a response port. Each primitive carries a come-again flag (CA), an instruction-address flag (PC) and an interrupt-allowed flag (IA). The host consumes one primitive per read strobe.

The series has four steps. The first step asks for the instruction address, and for the dynamic k-factor format it also asks for a host data register. The second step is a wait that repeats while the conversion datapath reports busy. The third step moves the converted operand out. The fourth step releases the host, or ends the dialog with a mid-instruction exception when the conversion faulted. The captured format and static k-factor are presented to the conversion datapath, which is outside this block.

Top module: `cp_store_resp_seq`

## Requirements
- R1: After reset `cmd_ready_o`=1, `resp_valid_o`=0, `resp_prim_o`=0, all flags 0, and `op_fmt_o`, `kfactor_o`, `resp_size_o` and `resp_reg_o` are 0.
- R2: A command is accepted only when `cmd_ready_o`=1, which holds only in idle. A `cmd_valid_i` seen at any other time has no effect on `op_fmt_o`, `kfactor_o` or the response series. This includes a command in the same cycle as the final read.
- R3: In the cycle after acceptance, for format codes 0..6 the response is a null primitive (code 1) with CA=1, IA=0 and `resp_reg_o`=0.
- R4: For format code 7 (packed decimal, dynamic k-factor) the first response is transfer-host-register (code 2) with CA=1 and IA=0. `resp_reg_o` equals extension bits 6..4, and extension bits 3..0 have no effect.
- R5: The PC flag of the first response equals the OR of all `exc_en_i` bits captured with the command. It is 0 in every other response.
- R6: The second response is a null (code 1) with CA=1 and IA=1. A read while `conv_busy_i`=1 repeats it. A read while `conv_busy_i`=0 moves on.
- R7: The third response is evaluate-address-and-transfer (code 3) with CA=1. `resp_size_o` is 1 for format 6, 2 for format 4, 4 for formats 0 and 1, 8 for format 5, and 12 for formats 2, 3 and 7. It is 0 in every other response.
- R8: The fourth response has CA=0. It is take-mid-instruction-exception (code 4) if `conv_exc_i` was 1 on the read that left the wait step, and a null (code 1) otherwise.
- R9: The series advances exactly one step per `resp_rd_i` while `resp_valid_o`=1 and holds without a read. The read of the fourth response returns the block to idle.
- R10: For format 3, `kfactor_o` is the extension field. For every other format it is 0. A nonzero extension field under formats 0,1,2,4,5,6 does not change the response series.
- R11: The captured format on `op_fmt_o` and the k-factor stay constant from acceptance until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_fmt_i | input | 3 | Destination-format code |
| cmd_ext_i | input | 7 | Extension field |
| exc_en_i | input | 8 | Exception-enable bits |
| cmd_ready_o | output | 1 | Idle, command can be taken |
| conv_busy_i | input | 1 | Conversion in progress |
| conv_exc_i | input | 1 | Conversion raised an exception |
| resp_rd_i | input | 1 | Host reads the response port |
| resp_valid_o | output | 1 | A primitive is presented |
| resp_prim_o | output | 3 | Primitive code (0 none, 1 null, 2 transfer register, 3 address+data, 4 take exception) |
| resp_ca_o | output | 1 | Come-again flag |
| resp_pc_o | output | 1 | Instruction-address transfer flag |
| resp_ia_o | output | 1 | Interrupt-allowed flag |
| resp_size_o | output | 4 | Operand transfer size in bytes |
| resp_reg_o | output | 3 | Host data register number |
| op_fmt_o | output | 3 | Captured format for the datapath |
| kfactor_o | output | 7 | Captured static k-factor |

## Verification
Two events can land in the same cycle. The host's read of the termination primitive, which returns the block to idle, can coincide with a new command strobe, which the block must drop. The bench drives both at once and then checks that the block is idle and presents nothing. It also checks that the captured format and k-factor still belong to the previous command. In the same way, `conv_busy_i` falling together with a read of the wait primitive is provoked with random wait lengths, including zero. The bench checks that the block leaves the wait step after exactly the expected number of reads.

// File: rtl/cp_store_pkg.sv
package cp_store_pkg;
  localparam int FMT_W  = 3;
  localparam int SIZE_W = 4;
  localparam int REG_W  = 3;

  typedef enum logic [2:0] {
    P_NONE    = 3'd0,
    P_NULL    = 3'd1,
    P_XREG    = 3'd2,
    P_EADATA  = 3'd3,
    P_TAKEEXC = 3'd4
  } prim_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FIRST = 3'd1,
    S_WAIT  = 3'd2,
    S_XFER  = 3'd3,
    S_TERM  = 3'd4
  } seq_state_e;

  localparam logic [FMT_W-1:0] FMT_PKD_STATIC  = 3'd3;
  localparam logic [FMT_W-1:0] FMT_PKD_DYNAMIC = 3'd7;

  function automatic logic [SIZE_W-1:0] fmt_size(logic [FMT_W-1:0] fmt);
    case (fmt)
      3'd6:          fmt_size = 4'd1;
      3'd4:          fmt_size = 4'd2;
      3'd0, 3'd1:    fmt_size = 4'd4;
      3'd5:          fmt_size = 4'd8;
      default:       fmt_size = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/cp_cmd_latch.sv
module cp_cmd_latch
  import cp_store_pkg::*;
#(
  parameter int EXT_W = 7,
  parameter int EN_W  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   accept_i,
  input  logic [FMT_W-1:0]       fmt_i,
  input  logic [EXT_W-1:0]       ext_i,
  input  logic [EN_W-1:0]        en_i,
  output logic [FMT_W-1:0]       fmt_o,
  output logic [EXT_W-1:0]       kfactor_o,
  output logic [REG_W-1:0]       kreg_o,
  output logic                   dyn_o,
  output logic                   pc_req_o,
  output logic [SIZE_W-1:0]      size_o
);
  localparam int REG_LSB = EXT_W - REG_W;

  logic [FMT_W-1:0]  fmt_q;
  logic [EXT_W-1:0]  kfac_q;
  logic [REG_W-1:0]  kreg_q;
  logic              pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= '0;
      kfac_q <= '0;
      kreg_q <= '0;
      pc_q   <= 1'b0;
    end else if (accept_i) begin
      fmt_q  <= fmt_i;
      // static k only meaningful for packed-static; other formats ignore ext
      kfac_q <= (fmt_i == FMT_PKD_STATIC) ? ext_i : '0;
      // dynamic: upper bits name host register, low bits ignored
      kreg_q <= (fmt_i == FMT_PKD_DYNAMIC) ? ext_i[EXT_W-1:REG_LSB] : '0;
      pc_q   <= |en_i;
    end
  end

  assign fmt_o     = fmt_q;
  assign kfactor_o = kfac_q;
  assign kreg_o    = kreg_q;
  assign dyn_o     = (fmt_q == FMT_PKD_DYNAMIC);
  assign pc_req_o  = pc_q;
  assign size_o    = fmt_size(fmt_q);

  a_r11_capture_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> ($stable(fmt_q) && $stable(kfac_q) && $stable(kreg_q)));
  a_r10_kfac_only_static: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kfac_q != '0) |-> (fmt_q == FMT_PKD_STATIC));
endmodule

// File: rtl/cp_resp_fsm.sv
module cp_resp_fsm
  import cp_store_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic       rd_i,
  input  logic       busy_i,
  input  logic       exc_i,
  output logic       accept_o,
  output seq_state_e state_o,
  output logic       exc_o
);
  seq_state_e state_q, state_d;
  logic       exc_q;

  assign accept_o = cmd_valid_i && (state_q == S_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (cmd_valid_i) state_d = S_FIRST;
      S_FIRST: if (rd_i) state_d = S_WAIT;
      S_WAIT:  if (rd_i && !busy_i) state_d = S_XFER;
      S_XFER:  if (rd_i) state_d = S_TERM;
      S_TERM:  if (rd_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      exc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) exc_q <= 1'b0;
      else if (state_q == S_WAIT && rd_i && !busy_i) exc_q <= exc_i;
    end
  end

  assign state_o = state_q;
  assign exc_o   = exc_q;

  a_r6_wait_repeats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && rd_i && busy_i) |=> (state_q == S_WAIT));
  a_r9_hold_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && !rd_i) |=> $stable(state_q));
  a_r9_term_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TERM && rd_i) |=> (state_q == S_IDLE));
  a_r2_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && cmd_valid_i) |=> (state_q == S_FIRST));
endmodule

// File: rtl/cp_resp_encode.sv
module cp_resp_encode
  import cp_store_pkg::*;
(
  input  seq_state_e        state_i,
  input  logic              dyn_i,
  input  logic              pc_req_i,
  input  logic              exc_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [REG_W-1:0]  kreg_i,
  output logic              valid_o,
  output prim_e             prim_o,
  output logic              ca_o,
  output logic              pc_o,
  output logic              ia_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [REG_W-1:0]  reg_o
);
  always_comb begin
    valid_o = 1'b1;
    prim_o  = P_NULL;
    ca_o    = 1'b1;
    pc_o    = 1'b0;
    ia_o    = 1'b0;
    size_o  = '0;
    reg_o   = '0;
    case (state_i)
      S_FIRST: begin
        prim_o = dyn_i ? P_XREG : P_NULL;
        pc_o   = pc_req_i;
        reg_o  = dyn_i ? kreg_i : '0;
      end
      S_WAIT:  ia_o = 1'b1;
      S_XFER: begin
        prim_o = P_EADATA;
        size_o = size_i;
      end
      S_TERM: begin
        prim_o = exc_i ? P_TAKEEXC : P_NULL;
        ca_o   = 1'b0;
      end
      default: begin
        valid_o = 1'b0;
        prim_o  = P_NONE;
        ca_o    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cp_store_resp_seq.sv
module cp_store_resp_seq
  import cp_store_pkg::*;
#(
  parameter int EXT_W = 7,
  parameter int EN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_fmt_i,
  input  logic [EXT_W-1:0]  cmd_ext_i,
  input  logic [EN_W-1:0]   exc_en_i,
  output logic              cmd_ready_o,
  input  logic              conv_busy_i,
  input  logic              conv_exc_i,
  input  logic              resp_rd_i,
  output logic              resp_valid_o,
  output logic [2:0]        resp_prim_o,
  output logic              resp_ca_o,
  output logic              resp_pc_o,
  output logic              resp_ia_o,
  output logic [3:0]        resp_size_o,
  output logic [2:0]        resp_reg_o,
  output logic [2:0]        op_fmt_o,
  output logic [EXT_W-1:0]  kfactor_o
);
  logic              accept;
  seq_state_e        state;
  logic              exc_q;
  logic              dyn, pc_req;
  logic [SIZE_W-1:0] size;
  logic [REG_W-1:0]  kreg;
  prim_e             prim;
  logic              rd_eff;

  assign rd_eff = resp_rd_i && resp_valid_o;

  cp_resp_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .rd_i        (rd_eff),
    .busy_i      (conv_busy_i),
    .exc_i       (conv_exc_i),
    .accept_o    (accept),
    .state_o     (state),
    .exc_o       (exc_q)
  );

  cp_cmd_latch #(.EXT_W(EXT_W), .EN_W(EN_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .fmt_i     (cmd_fmt_i),
    .ext_i     (cmd_ext_i),
    .en_i      (exc_en_i),
    .fmt_o     (op_fmt_o),
    .kfactor_o (kfactor_o),
    .kreg_o    (kreg),
    .dyn_o     (dyn),
    .pc_req_o  (pc_req),
    .size_o    (size)
  );

  cp_resp_encode u_enc (
    .state_i  (state),
    .dyn_i    (dyn),
    .pc_req_i (pc_req),
    .exc_i    (exc_q),
    .size_i   (size),
    .kreg_i   (kreg),
    .valid_o  (resp_valid_o),
    .prim_o   (prim),
    .ca_o     (resp_ca_o),
    .pc_o     (resp_pc_o),
    .ia_o     (resp_ia_o),
    .size_o   (resp_size_o),
    .reg_o    (resp_reg_o)
  );

  assign resp_prim_o = prim;
  assign cmd_ready_o = (state == S_IDLE);

  a_r2_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !resp_valid_o);
  a_r5_pc_with_ca: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_pc_o |-> (resp_ca_o && !resp_ia_o && resp_size_o == '0));
  a_r7_size_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_size_o != '0) |-> (resp_prim_o == 3'd3 && resp_ca_o));
  a_r8_exc_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_prim_o == 3'd4 && resp_rd_i) |=> cmd_ready_o);
  a_r3_first_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && cmd_valid_i) |=> (resp_valid_o && resp_ca_o && !resp_ia_o));
endmodule

// File: tb/tb_cp_store_resp_seq.sv
module tb_cp_store_resp_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_fmt = '0;
  logic [6:0] cmd_ext = '0;
  logic [7:0] exc_en = '0;
  logic       busy = 1'b0, cexc = 1'b0, rd = 1'b0;
  logic       ready, rvalid, ca, pc, ia;
  logic [2:0] prim, rreg, ofmt;
  logic [3:0] rsize;
  logic [6:0] kfac;

  int n_chk = 0, n_bad = 0;

  cp_store_resp_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_fmt_i(cmd_fmt),
    .cmd_ext_i(cmd_ext), .exc_en_i(exc_en), .cmd_ready_o(ready),
    .conv_busy_i(busy), .conv_exc_i(cexc), .resp_rd_i(rd), .resp_valid_o(rvalid),
    .resp_prim_o(prim), .resp_ca_o(ca), .resp_pc_o(pc), .resp_ia_o(ia),
    .resp_size_o(rsize), .resp_reg_o(rreg), .op_fmt_o(ofmt), .kfactor_o(kfac)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_size(logic [2:0] f);
    case (f)
      3'd6: return 1;
      3'd4: return 2;
      3'd0, 3'd1: return 4;
      3'd5: return 8;
      default: return 12;
    endcase
  endfunction

  // pack presented response: valid,prim,ca,pc,ia,size,reg
  function automatic int pack(logic v, logic [2:0] p, logic c, logic x, logic i,
                              logic [3:0] s, logic [2:0] r);
    return {v, p, c, x, i, s, r};
  endfunction

  function automatic int got_resp();
    return pack(rvalid, prim, ca, pc, ia, rsize, rreg);
  endfunction

  task automatic check_idle(string req);
    chk({req, " ready"}, ready, 1);
    chk({req, " idle response"}, got_resp(), 0);
  endtask

  task automatic run_cmd(logic [2:0] f, logic [6:0] e, logic [7:0] en,
                         int nwait, logic ex, int stall, logic collide);
    logic dynf;
    logic [2:0] prev_fmt;
    logic [6:0] prev_k;
    dynf = (f == 3'd7);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_fmt = f; cmd_ext = e; exc_en = en; rd = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    // R3 R4 R5 first response
    chk(dynf ? "R4 first" : "R3 first", got_resp(),
        pack(1, dynf ? 3'd2 : 3'd1, 1, |en, 0, 0, dynf ? e[6:4] : 3'd0));
    chk("R10 kfactor", kfac, (f == 3'd3) ? int'(e) : 0);
    chk("R11 fmt", ofmt, f);
    prev_fmt = ofmt; prev_k = kfac;
    for (int s = 0; s < stall; s++) begin
      cmd_valid = 1'b1; cmd_fmt = ~f; cmd_ext = ~e;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R9 stall holds", got_resp(),
          pack(1, dynf ? 3'd2 : 3'd1, 1, |en, 0, 0, dynf ? e[6:4] : 3'd0));
      chk("R2 mid cmd fmt", ofmt, prev_fmt);
      chk("R2 mid cmd k", kfac, prev_k);
    end
    rd = 1'b1;
    for (int i = 0; i <= nwait; i++) begin
      @(negedge clk);
      chk("R6 wait", got_resp(), pack(1, 3'd1, 1, 0, 1, 0, 0));
      busy = (i < nwait);
      cexc = (i == nwait) ? ex : ~ex;
    end
    @(negedge clk);
    busy = 1'b0; cexc = 1'b0;
    chk("R7 xfer", got_resp(), pack(1, 3'd3, 1, 0, 0, exp_size(f), 0));
    @(negedge clk);
    chk("R8 term", got_resp(), pack(1, ex ? 3'd4 : 3'd1, 0, 0, 0, 0, 0));
    if (collide) begin
      cmd_valid = 1'b1; cmd_fmt = ~f; cmd_ext = ~e;
    end
    @(negedge clk);
    cmd_valid = 1'b0; rd = 1'b0;
    check_idle("R9 back to idle");
    chk("R2 collide fmt", ofmt, prev_fmt);
    chk("R2 collide k", kfac, prev_k);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset state
    check_idle("R1");
    chk("R1 fmt", ofmt, 0);
    chk("R1 k", kfac, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");
    // directed corners
    run_cmd(3'd0, 7'h7f, 8'h00, 0, 0, 0, 1);   // R10 nonzero ext ignored, R5 pc off
    run_cmd(3'd7, 7'h5f, 8'h01, 2, 1, 1, 1);   // R4 low bits ignored, R8 exception
    run_cmd(3'd3, 7'h2a, 8'h80, 0, 1, 0, 0);   // R10 static k
    run_cmd(3'd6, 7'h01, 8'h00, 3, 0, 2, 1);   // R7 byte size
    for (int n = 0; n < 300; n++) begin
      run_cmd(3'($urandom % 8), 7'($urandom),
              ($urandom % 2) ? 8'($urandom) : 8'h00,
              int'($urandom % 5), 1'($urandom % 4 == 0),
              int'($urandom % 3), 1'($urandom % 2));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule